// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selector

This unit accepts two IEEE-754 operands of the same precision and returns either the smaller or the larger of the two. A precision select chooses between single precision (32-bit) and double precision (64-bit) for both operands. An operation select chooses minimum or maximum. Each operand is classified as signalling NaN, quiet NaN, infinity, zero, denormal or normal. A fixed priority of special-case rules is applied first. If none of those rules applies, the unit falls back to a sign comparison and then a magnitude comparison.

The unit never rounds or does arithmetic. Its output is always one of the following:
- an input operand, unchanged;
- an input operand with its quiet bit forced on;
- a default quiet NaN.

A two-bit status code comes with each result and marks invalid operations. Results are registered and appear one clock after the input strobe.

The output stage is a two-state machine. In OUT_EMPTY, `res_valid` is low. In OUT_FULL, `res_valid` is high and the registered result is presented. Every clock edge takes the transition EMPTY_TO_FULL or FULL_TO_FULL when `req_valid` is high. It takes FULL_TO_EMPTY or EMPTY_TO_EMPTY when `req_valid` is low. Reset forces OUT_EMPTY.

Top module: `fp_minmax_unit`

## Requirements
- R1: `res_valid` is high exactly one clock after a cycle with `req_valid` high, and that result belongs to the operands sampled in that cycle. It is low one clock after a cycle with `req_valid` low.
- R2: If the left operand is a signalling NaN, the result is the left operand with its quiet bit set, and status is 1. This rule takes priority over everything else. A signalling NaN has an all-ones exponent, a non-zero fraction, and the most significant fraction bit clear. The quiet bit is bit 22 in single precision and bit 51 in double precision.
- R3: If only the right operand is a signalling NaN, the result is the right operand with its quiet bit set, and status is 1. This holds even when the left operand is a quiet NaN.
- R4: If neither operand is a signalling NaN and at least one is a quiet NaN, that NaN is returned unchanged with status 0. The left operand wins when both are quiet NaNs. A quiet NaN has an all-ones exponent and the most significant fraction bit set.
- R5: Two infinities of the same sign give the default quiet NaN with status 2. The default quiet NaN is 0x7FC00000 in single precision and 0x7FF8000000000000 in double precision.
- R6: Negative infinity orders below every other non-NaN value, and positive infinity orders above every other non-NaN value. This includes a pair of opposite-sign infinities.
- R7: When the signs differ, maximum returns the positive operand and minimum returns the negative operand. This applies to +0 versus −0 as well.
- R8: When the signs are equal, magnitude is decided by the exponent field first and then by the fraction field, and denormals are compared by raw field value. For negative operands, the larger magnitude is the smaller value.
- R9: In single precision, only bits 31:0 of each operand are used. Bits 63:32 of the inputs are ignored, and bits 63:32 of the result are zero. In double precision, sign is bit 63, the exponent is bits 62:52 and the fraction is bits 51:0. In single precision, sign is bit 31, the exponent is bits 30:23 and the fraction is bits 22:0.
- R10: While reset (`rst_n` low at a clock edge) is applied, `res_valid` is low, and a request presented in the reset cycle produces no result.
- R11: Status is 0 for every result that is not covered by R2, R3 or R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operands and selects are valid this cycle |
| is_double | input | 1 | 1 = double precision, 0 = single precision |
| want_max | input | 1 | 1 = maximum, 0 = minimum |
| opnd_l | input | 64 | Left operand |
| opnd_r | input | 64 | Right operand |
| res_valid | output | 1 | Registered result is valid |
| res_value | output | 64 | Selected operand, quietened NaN, or default NaN |
| res_status | output | 2 | 0 none, 1 invalid signalling NaN, 2 invalid same-sign infinities |

## Verification
A wrong classification or a wrong rule order shows up on the very next `res_valid` cycle. The result is then the other operand, a NaN without its quiet bit set, or a status code that disagrees with the chosen value. A stuck output state shows as `res_valid` not following `req_valid` with a one-clock lag, or as a result arriving for a request made during reset. Each result is compared against a model that orders values through a signed key, which is a different method from the rule chain in the design. Both precisions, both operation selects, every NaN and infinity pairing, and signed zeros are exercised.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
    localparam int WORD_W    = 64;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;

    typedef enum logic [2:0] {
        CLS_ZERO, CLS_DENORM, CLS_NORMAL, CLS_INF, CLS_QNAN, CLS_SNAN
    } fmm_class_e;

    typedef enum logic [1:0] {
        ST_NONE     = 2'd0,
        ST_BAD_SNAN = 2'd1,
        ST_BAD_INF  = 2'd2
    } fmm_status_e;

    typedef enum logic [2:0] {
        SRC_LEFT, SRC_RIGHT, SRC_LEFT_QUIET, SRC_RIGHT_QUIET, SRC_DEFNAN
    } fmm_src_e;

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } fmm_out_state_e;

    // operand widened to double-precision field widths
    typedef struct packed {
        logic                 sign;
        logic [DP_EXP_W-1:0]  exp;
        logic [DP_FRAC_W-1:0] frac;
        fmm_class_e           cls;
    } fmm_opnd_t;
endpackage

// File: rtl/fmm_classify.sv
module fmm_classify
    import fmm_pkg::*;
#(
    parameter int WORD_W_P    = WORD_W,
    parameter int DP_EXP_W_P  = DP_EXP_W,
    parameter int DP_FRAC_W_P = DP_FRAC_W,
    parameter int SP_EXP_W_P  = SP_EXP_W,
    parameter int SP_FRAC_W_P = SP_FRAC_W
) (
    input  logic [WORD_W_P-1:0] word,
    input  logic                dbl,
    output fmm_opnd_t           opnd,
    output logic [WORD_W_P-1:0] clean,
    output logic [WORD_W_P-1:0] quieted
);
    localparam int SP_WORD_W = 1 + SP_EXP_W_P + SP_FRAC_W_P;
    localparam int HI_W      = WORD_W_P - SP_WORD_W;
    localparam int EXP_PAD   = DP_EXP_W_P - SP_EXP_W_P;
    localparam int FRAC_PAD  = DP_FRAC_W_P - SP_FRAC_W_P;

    logic                   sign_w;
    logic [DP_EXP_W_P-1:0]  exp_w;
    logic [DP_FRAC_W_P-1:0] frac_w;
    logic                   exp_all_ones;
    logic [WORD_W_P-1:0]    qmask;
    fmm_class_e             cls_w;

    always_comb begin
        if (dbl) begin
            sign_w       = word[WORD_W_P-1];
            exp_w        = word[WORD_W_P-2 -: DP_EXP_W_P];
            frac_w       = word[DP_FRAC_W_P-1:0];
            exp_all_ones = &word[WORD_W_P-2 -: DP_EXP_W_P];
            clean        = word;
            qmask        = WORD_W_P'(1) << (DP_FRAC_W_P - 1);
        end else begin
            sign_w       = word[SP_WORD_W-1];
            exp_w        = {{EXP_PAD{1'b0}}, word[SP_WORD_W-2 -: SP_EXP_W_P]};
            frac_w       = {word[SP_FRAC_W_P-1:0], {FRAC_PAD{1'b0}}};
            exp_all_ones = &word[SP_WORD_W-2 -: SP_EXP_W_P];
            clean        = {{HI_W{1'b0}}, word[SP_WORD_W-1:0]};
            qmask        = WORD_W_P'(1) << (SP_FRAC_W_P - 1);
        end
    end

    always_comb begin
        if (exp_all_ones) begin
            if (frac_w == '0)                 cls_w = CLS_INF;
            else if (frac_w[DP_FRAC_W_P-1])   cls_w = CLS_QNAN;
            else                              cls_w = CLS_SNAN;
        end else if (exp_w == '0) begin
            cls_w = (frac_w == '0) ? CLS_ZERO : CLS_DENORM;
        end else begin
            cls_w = CLS_NORMAL;
        end
    end

    assign opnd    = '{sign: sign_w, exp: exp_w, frac: frac_w, cls: cls_w};
    assign quieted = clean | qmask;
endmodule

// File: rtl/fmm_decide.sv
module fmm_decide
    import fmm_pkg::*;
(
    input  fmm_opnd_t   lhs,
    input  fmm_opnd_t   rhs,
    input  logic        op_max,
    output fmm_src_e    src,
    output fmm_status_e status
);
    logic mag_l_gt;
    logic left_is_max;

    assign mag_l_gt = {lhs.exp, lhs.frac} > {rhs.exp, rhs.frac};

    always_comb begin
        src         = SRC_LEFT;
        status      = ST_NONE;
        left_is_max = 1'b0;
        if (lhs.cls == CLS_SNAN) begin
            src    = SRC_LEFT_QUIET;
            status = ST_BAD_SNAN;
        end else if (rhs.cls == CLS_SNAN) begin
            src    = SRC_RIGHT_QUIET;
            status = ST_BAD_SNAN;
        end else if (lhs.cls == CLS_QNAN) begin
            src = SRC_LEFT;
        end else if (rhs.cls == CLS_QNAN) begin
            src = SRC_RIGHT;
        end else if (lhs.cls == CLS_INF && rhs.cls == CLS_INF
                     && lhs.sign == rhs.sign) begin
            src    = SRC_DEFNAN;
            status = ST_BAD_INF;
        end else begin
            if (lhs.cls == CLS_INF)          left_is_max = !lhs.sign;
            else if (rhs.cls == CLS_INF)     left_is_max = rhs.sign;
            else if (lhs.sign != rhs.sign)   left_is_max = !lhs.sign;
            else if (mag_l_gt)               left_is_max = !lhs.sign;
            else                             left_is_max = lhs.sign;
            src = (op_max == left_is_max) ? SRC_LEFT : SRC_RIGHT;
        end
    end
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
    import fmm_pkg::*;
#(
    parameter int WORD_W_P    = WORD_W,
    parameter int DP_EXP_W_P  = DP_EXP_W,
    parameter int DP_FRAC_W_P = DP_FRAC_W,
    parameter int SP_EXP_W_P  = SP_EXP_W,
    parameter int SP_FRAC_W_P = SP_FRAC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                is_double,
    input  logic                want_max,
    input  logic [WORD_W_P-1:0] opnd_l,
    input  logic [WORD_W_P-1:0] opnd_r,
    output logic                res_valid,
    output logic [WORD_W_P-1:0] res_value,
    output logic [1:0]          res_status
);
    localparam int SP_WORD_W = 1 + SP_EXP_W_P + SP_FRAC_W_P;
    localparam int HI_W      = WORD_W_P - SP_WORD_W;
    localparam int N_OPND    = 2;
    localparam logic [WORD_W_P-1:0] DQNAN_DP =
        {1'b0, {DP_EXP_W_P{1'b1}}, 1'b1, {(DP_FRAC_W_P-1){1'b0}}};
    localparam logic [WORD_W_P-1:0] DQNAN_SP =
        {{HI_W{1'b0}}, 1'b0, {SP_EXP_W_P{1'b1}}, 1'b1, {(SP_FRAC_W_P-1){1'b0}}};

    logic [WORD_W_P-1:0] words   [N_OPND];
    logic [WORD_W_P-1:0] cleans  [N_OPND];
    logic [WORD_W_P-1:0] quiets  [N_OPND];
    fmm_opnd_t           opnds   [N_OPND];

    assign words[0] = opnd_l;
    assign words[1] = opnd_r;

    for (genvar g = 0; g < N_OPND; g++) begin : g_cls
        fmm_classify #(
            .WORD_W_P(WORD_W_P), .DP_EXP_W_P(DP_EXP_W_P), .DP_FRAC_W_P(DP_FRAC_W_P),
            .SP_EXP_W_P(SP_EXP_W_P), .SP_FRAC_W_P(SP_FRAC_W_P)
        ) u_cls (
            .word(words[g]), .dbl(is_double), .opnd(opnds[g]),
            .clean(cleans[g]), .quieted(quiets[g])
        );
    end

    fmm_src_e    src;
    fmm_status_e status_d;

    fmm_decide u_decide (
        .lhs(opnds[0]), .rhs(opnds[1]), .op_max(want_max),
        .src(src), .status(status_d)
    );

    logic [WORD_W_P-1:0] value_d;
    always_comb begin
        unique case (src)
            SRC_LEFT:        value_d = cleans[0];
            SRC_RIGHT:       value_d = cleans[1];
            SRC_LEFT_QUIET:  value_d = quiets[0];
            SRC_RIGHT_QUIET: value_d = quiets[1];
            SRC_DEFNAN:      value_d = is_double ? DQNAN_DP : DQNAN_SP;
            default:         value_d = '0;
        endcase
    end

    // output stage state machine
    fmm_out_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            OUT_EMPTY: state_d = req_valid ? OUT_FULL : OUT_EMPTY;
            OUT_FULL:  state_d = req_valid ? OUT_FULL : OUT_EMPTY;
            default:   state_d = OUT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OUT_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_value  <= '0;
            res_status <= ST_NONE;
        end else if (req_valid) begin
            res_value  <= value_d;
            res_status <= status_d;
        end
    end

    assign res_valid = (state_q == OUT_FULL);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    // R5
    inf_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == ST_BAD_INF) |->
        (res_value == ($past(is_double) ? DQNAN_DP : DQNAN_SP)));
    // R2
    snan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == ST_BAD_SNAN) |->
        ($past(is_double) ? (res_value[DP_FRAC_W_P-1] && (&res_value[WORD_W_P-2 -: DP_EXP_W_P]))
                          : (res_value[SP_FRAC_W_P-1] && (&res_value[SP_WORD_W-2 -: SP_EXP_W_P]))));
    // R9
    sp_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(is_double)) |-> (res_value[WORD_W_P-1:SP_WORD_W] == '0));
    // R11
    pick_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == ST_NONE) |->
        ($past(is_double)
            ? (res_value == $past(opnd_l) || res_value == $past(opnd_r))
            : (res_value[SP_WORD_W-1:0] == $past(opnd_l[SP_WORD_W-1:0]) ||
               res_value[SP_WORD_W-1:0] == $past(opnd_r[SP_WORD_W-1:0]))));
    // R11
    status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_status != 2'd3));
endmodule

// File: tb/fp_minmax_unit_tb.sv
`timescale 1ns/1ps
module fp_minmax_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        is_double = 1'b0;
    logic        want_max = 1'b0;
    logic [63:0] opnd_l = '0;
    logic [63:0] opnd_r = '0;
    logic        res_valid;
    logic [63:0] res_value;
    logic [1:0]  res_status;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit mon_en = 0;

    logic [63:0] q_val[$];
    logic [1:0]  q_st[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    fp_minmax_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_double(is_double),
        .want_max(want_max), .opnd_l(opnd_l), .opnd_r(opnd_r),
        .res_valid(res_valid), .res_value(res_value), .res_status(res_status)
    );

    function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                  input logic dbl, input logic mx,
                                  output logic [63:0] r, output logic [1:0] s);
        logic [10:0] ea, eb, emax;
        logic [51:0] fa, fb;
        logic sa, sb;
        logic [63:0] ca, cb, qm, dn;
        logic signed [64:0] ka, kb;
        logic lt;
        if (dbl) begin
            ea = a[62:52]; fa = a[51:0]; sa = a[63];
            eb = b[62:52]; fb = b[51:0]; sb = b[63];
            emax = 11'h7FF; ca = a; cb = b;
            qm = 64'h0008_0000_0000_0000; dn = 64'h7FF8_0000_0000_0000;
        end else begin
            ea = {3'b0, a[30:23]}; fa = {a[22:0], 29'b0}; sa = a[31];
            eb = {3'b0, b[30:23]}; fb = {b[22:0], 29'b0}; sb = b[31];
            emax = 11'h0FF; ca = {32'b0, a[31:0]}; cb = {32'b0, b[31:0]};
            qm = 64'h0000_0000_0040_0000; dn = 64'h0000_0000_7FC0_0000;
        end
        s = 2'd0;
        if (ea == emax && fa != 0 && !fa[51])      begin r = ca | qm; s = 2'd1; end
        else if (eb == emax && fb != 0 && !fb[51]) begin r = cb | qm; s = 2'd1; end
        else if (ea == emax && fa != 0)            r = ca;
        else if (eb == emax && fb != 0)            r = cb;
        else if (ea == emax && eb == emax && sa == sb) begin r = dn; s = 2'd2; end
        else begin
            ka = $signed({2'b0, ea, fa});
            kb = $signed({2'b0, eb, fb});
            if (sa) ka = -ka;
            if (sb) kb = -kb;
            lt = (ka < kb) || (ka == kb && sa && !sb);
            if (mx) r = lt ? cb : ca;
            else    r = lt ? ca : cb;
        end
    endfunction

    task automatic send(input logic [63:0] a, input logic [63:0] b,
                        input logic dbl, input logic mx, input string tag);
        logic [63:0] ev;
        logic [1:0]  es;
        @(negedge clk);
        opnd_l = a; opnd_r = b; is_double = dbl; want_max = mx; req_valid = 1'b1;
        model(a, b, dbl, mx, ev, es);
        q_val.push_back(ev); q_st.push_back(es); q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic check_bit(input logic act, input logic exp_v, input string tag);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: res_valid=%b expected %b", tag, act, exp_v);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_en) begin
            if (res_valid) begin
                checks++;
                if (q_val.size() == 0) begin
                    fails++;
                    $display("FAIL R1 unexpected result: res_valid=1 expected 0");
                end else begin
                    logic [63:0] ev;
                    logic [1:0]  es;
                    string       tg;
                    ev = q_val.pop_front(); es = q_st.pop_front(); tg = q_tag.pop_front();
                    if (res_value !== ev || res_status !== es) begin
                        fails++;
                        $display("FAIL %s: result=%h status=%0d expected %h status=%0d",
                                 tg, res_value, res_status, ev, es);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: done=0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R10: reset holds res_valid low even with requests present
        @(negedge clk);
        req_valid = 1'b1; opnd_l = 64'h3F80_0000; opnd_r = 64'h4000_0000;
        @(negedge clk);
        check_bit(res_valid, 1'b0, "R10 in reset");
        @(negedge clk);
        req_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        check_bit(res_valid, 1'b0, "R10 after release");
        mon_en = 1'b1;

        // R2: left sNaN wins over right sNaN, single and double
        send(64'h7F80_0001, 64'hFF80_0005, 1'b0, 1'b1, "R2 sp both snan");
        send(64'h7FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000, 1'b1, 1'b0, "R2 dp left snan");
        send(64'hFF80_0003, 64'h7FC0_0001, 1'b0, 1'b0, "R2 snan over qnan");
        // R3: right sNaN beats left qNaN
        send(64'h7FC0_0001, 64'hFF80_0005, 1'b0, 1'b1, "R3 sp right snan");
        send(64'h7FF8_0000_0000_0002, 64'hFFF0_0000_0000_0009, 1'b1, 1'b0, "R3 dp right snan");
        // R4: quiet NaN passthrough, left priority
        send(64'h7FC0_0011, 64'hFFC0_0022, 1'b0, 1'b1, "R4 both qnan");
        send(64'h3F80_0000, 64'hFFC0_0022, 1'b0, 1'b0, "R4 right qnan");
        send(64'h7FF8_0000_0000_0002, 64'hFFF0_0000_0000_0000, 1'b1, 1'b1, "R4 qnan vs inf");
        // R5: same-sign infinities
        send(64'h7F80_0000, 64'h7F80_0000, 1'b0, 1'b1, "R5 sp +inf +inf");
        send(64'hFFF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 1'b1, 1'b0, "R5 dp -inf -inf");
        // R6: infinity ordering
        send(64'h7F80_0000, 64'hFF80_0000, 1'b0, 1'b1, "R6 +inf vs -inf max");
        send(64'h7F80_0000, 64'hFF80_0000, 1'b0, 1'b0, "R6 +inf vs -inf min");
        send(64'hFFF0_0000_0000_0000, 64'hC008_0000_0000_0000, 1'b1, 1'b1, "R6 -inf left max");
        send(64'h3FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1'b1, 1'b0, "R6 +inf right min");
        // R7: differing signs, including signed zeros
        send(64'hBF80_0000, 64'h0000_0001, 1'b0, 1'b1, "R7 neg vs denorm max");
        send(64'h0000_0000, 64'h8000_0000, 1'b0, 1'b1, "R7 +0 -0 max");
        send(64'h8000_0000, 64'h0000_0000, 1'b0, 1'b0, "R7 -0 +0 min");
        // R8: magnitude by exponent then fraction
        send(64'h4000_0000, 64'h3FC0_0000, 1'b0, 1'b1, "R8 exp decides max");
        send(64'h3FC0_0000, 64'h3F80_0000, 1'b0, 1'b0, "R8 frac decides min");
        send(64'hC000_0000, 64'hBF80_0000, 1'b0, 1'b1, "R8 negative max");
        send(64'hC008_0000_0000_0000, 64'hC000_0000_0000_0000, 1'b1, 1'b0, "R8 dp negative min");
        send(64'h0000_0002, 64'h0000_0001, 1'b0, 1'b0, "R8 denorm raw");
        // R9: upper input bits ignored in single precision
        send(64'hFFFF_FFFF_3F80_0000, 64'h1234_5678_4000_0000, 1'b0, 1'b0, "R9 upper ignored min");
        send(64'hFFFF_FFFF_7F80_0000, 64'h0000_0000_7F80_0000, 1'b0, 1'b1, "R9 upper ignored inf");
        // R1 + R11: back-to-back random mix
        for (int i = 0; i < 60; i++) begin
            logic [63:0] a, b;
            logic d;
            d = i[0];
            a = {$urandom(), $urandom()};
            b = {$urandom(), $urandom()};
            if (i % 5 == 0) b = a ^ 64'h1;
            send(a, b, d, i[1], "R11 random");
        end
        // R1: idle cycles produce no results
        idle(4);
        check_bit(res_valid, 1'b0, "R1 idle");
        // R10: request in a reset cycle is dropped
        mon_en = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check_bit(res_valid, 1'b0, "R10 mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_bit(res_valid, 1'b0, "R10 after second reset");
        mon_en = 1'b1;
        send(64'h3F80_0000, 64'hBF80_0000, 1'b0, 1'b0, "R7 after reset");
        idle(2);
        checks++;
        if (q_val.size() != 0) begin
            fails++;
            $display("FAIL R1 pending results: %0d expected 0", q_val.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule